// File: doc/BRIEF.md
# Compare match timer channel

This block is one channel of a compare match timer. An up-counter advances on count ticks taken from a selectable prescaler. The prescaler divides either the system clock or a slow reference tick. When the counter reaches the value in its compare register, the next count returns it to zero and sets a match flag. The flag can drive an interrupt request that stays high until software clears the flag. Software reaches three registers through a simple write port and a combinational read port: control/status, counter and compare. A level input lets the channel run.

A parameter picks one of two flavours. The narrow flavour has a 16-bit counter and a small control layout. The wide flavour has a 32-bit counter, an overflow flag, a single-shot or continuous mode, a request-type field and the reference-tick clock codes. In both flavours a counter write is held back until the reference tick has pulsed twice.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter reads 0, the compare register reads all ones, control/status reads 0 and `irq` is low.
- R2: The counter changes only while `run` is high, except when a deferred counter write lands. With `run` low, reference ticks and clock cycles leave it unchanged.
- R3: Clock select codes 0, 1, 2 and 3 count once every 8, 32, 128 and 512 system clocks. In the wide flavour, codes 4, 5, 6 and 7 count once every 8, 32, 128 and 1 reference ticks. Each prescaler restarts from zero whenever `run` is low.
- R4: On a count where the counter equals the compare value, the counter becomes 0 and the match flag sets, so one period is compare + 1 counts. The match flag is bit 15 in the wide flavour and bit 7 in the narrow flavour.
- R5: In the wide flavour, bit 14 (overflow) sets when a count takes the counter from all ones to zero without a match.
- R6: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. Writable bits take the written value, and all other bits read 0. Wide writable bits: 8, 7, 5:4, 2:0. Narrow writable bits: 6, 1:0. A match in the same cycle as a clearing write leaves the flag set. Select codes are 0 control, 1 counter and 2 compare; code 3 reads 0.
- R7: A counter write takes effect at the second reference tick after the write. Until then, reads return the running count and, in the wide flavour, bit 13 reads 1.
- R8: The compare register can be rewritten while running, and the next count uses the new value.
- R9: Wide bit 8 = 1 counts continuously. With bit 8 = 0, after a match the counter holds at 0 until the match flag is cleared.
- R10: In the wide flavour, `irq` = match flag AND (bit 7 OR bits 5:4 = 2'b10). Request type 2'b01 does not raise `irq`. `irq` stays high until the flag is cleared.
- R11: In the narrow flavour, `irq` = bit 7 AND bit 6, and the 16-bit counter wraps at the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Channel counts while high |
| ref_tick | input | 1 | One-cycle enable pulse of the slow reference clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 counter, 2 compare |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Read source, same coding, 3 reads 0 |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: a software write that clears the match flag, and a count that hits the compare value and sets it again. The bench places a reference tick on the same edge as a clearing write while the counter sits on the compare value. It expects the flag still set and the counter at zero. The second collision is a deferred counter load arriving on a counting tick; there the bench expects the loaded value and no increment.

// File: rtl/cmt_pkg.sv
// Shared types for the compare match timer channel.
// Assumes: control/status is 16 bits wide in both flavours.
package cmt_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Count tick source: system clock or reference tick, divided by 2**shift
    typedef struct packed {
        logic       from_ref;
        logic [3:0] shift;
    } tick_src_t;

    localparam int CTRL_W = 16;

    // Decode the clock select field into a tick source
    function automatic tick_src_t decode_cks(input logic wide, input logic [2:0] code);
        tick_src_t s;
        s.from_ref = 1'b0;
        s.shift    = 4'd3 + {1'b0, code[1:0], 1'b0};
        if (wide && code[2]) begin
            s.from_ref = 1'b1;
            case (code[1:0])
                2'd0:    s.shift = 4'd3;
                2'd1:    s.shift = 4'd5;
                2'd2:    s.shift = 4'd7;
                default: s.shift = 4'd0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
// Count tick generator. Divides the system clock or the reference tick
// by a power of two picked by the decoded clock select.
// Assumes: both divider counters restart while run is low.
module cmt_prescale
    import cmt_pkg::*;
#(
    parameter int CLK_DIV_W = 9,
    parameter int REF_DIV_W = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      ref_tick_i,
    input  tick_src_t src_i,
    output logic      cnt_en_o
);

    logic [CLK_DIV_W-1:0] clk_q;
    logic [REF_DIV_W-1:0] ref_q;
    logic [CLK_DIV_W-1:0] clk_mask;
    logic [REF_DIV_W-1:0] ref_mask;
    logic                 clk_hit;
    logic                 ref_hit;

    // Divider counters, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            clk_q <= '0;
            ref_q <= '0;
        end else begin
            clk_q <= clk_q + 1'b1;
            if (ref_tick_i) begin
                ref_q <= ref_q + 1'b1;
            end
        end
    end

    // Masks selecting the low divider bits that must all be one
    always_comb begin
        for (int i = 0; i < CLK_DIV_W; i++) begin
            clk_mask[i] = (i < int'(src_i.shift));
        end
        for (int j = 0; j < REF_DIV_W; j++) begin
            ref_mask[j] = (j < int'(src_i.shift));
        end
    end

    // Tick decision for the selected source
    always_comb begin
        clk_hit  = &(clk_q | ~clk_mask);
        ref_hit  = ref_tick_i && (&(ref_q | ~ref_mask));
        cnt_en_o = run_i && (src_i.from_ref ? ref_hit : clk_hit);
    end

    // R3: dividers restart while the channel is stopped
    a_r3_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (clk_q == '0 && ref_q == '0));

endmodule

// File: rtl/cmt_counter.sv
// Counter, compare register and deferred counter-write path.
// Assumes: a counter write lands on the SYNC_TICKS-th reference tick
// after it; a newer write restarts the wait.
module cmt_counter #(
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             cnt_en_i,
    input  logic             hold_i,
    input  logic             ref_tick_i,
    input  logic             wr_cnt_i,
    input  logic             wr_cmp_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             pend_o,
    output logic             match_hit_o,
    output logic             wrap_hit_o
);

    localparam int SW = $clog2(SYNC_TICKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] pend_val_q;
    logic [SW-1:0]    pend_cnt_q;
    logic             pend_q;
    logic             load_w;
    logic             step_w;

    // Decide between deferred load and a normal count
    always_comb begin
        load_w      = pend_q && ref_tick_i && !wr_cnt_i &&
                      (pend_cnt_q == SW'(SYNC_TICKS - 1));
        step_w      = cnt_en_i && !hold_i && !load_w;
        match_hit_o = step_w && (cnt_q == cmp_q);
        wrap_hit_o  = step_w && (cnt_q == '1) && (cnt_q != cmp_q);
    end

    // Deferred counter write: capture value and count reference ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_cnt_q <= '0;
            pend_val_q <= '0;
        end else if (wr_cnt_i) begin
            pend_q     <= 1'b1;
            pend_cnt_q <= '0;
            pend_val_q <= wdata_i;
        end else if (load_w) begin
            pend_q     <= 1'b0;
        end else if (pend_q && ref_tick_i) begin
            pend_cnt_q <= pend_cnt_q + 1'b1;
        end
    end

    // Counter: load, clear on match, or increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_w) begin
            cnt_q <= pend_val_q;
        end else if (match_hit_o) begin
            cnt_q <= '0;
        end else if (step_w) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare register, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (wr_cmp_i) begin
            cmp_q <= wdata_i;
        end
    end

    assign cnt_o  = cnt_q;
    assign cmp_o  = cmp_q;
    assign pend_o = pend_q;

    // R2: without run and without a landing write the counter holds
    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_w) |=> $stable(cnt_q));

    // R4: a count at the compare value returns the counter to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !hold_i && !load_w && cnt_q == cmp_q) |=> (cnt_q == '0));

    // R7: a counter write opens the pending window
    a_r7_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> pend_q);

    // R9: a held counter does not move unless a write lands
    a_r9_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_w) |=> $stable(cnt_q));

endmodule

// File: rtl/cmt_ctrl.sv
// Control/status register, flags and interrupt request.
// Assumes: flags clear by writing 0 and a hardware set wins over a clear
// in the same cycle. WIDE selects the 32-bit-counter layout.
module cmt_ctrl
    import cmt_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              match_hit_i,
    input  logic              wrap_hit_i,
    input  logic              pend_i,
    output logic [CTRL_W-1:0] ctrl_rd_o,
    output tick_src_t         src_o,
    output logic              hold_o,
    output logic              irq_o
);

    localparam int CMF_BIT = WIDE ? 15 : 7;
    localparam int IE_BIT  = WIDE ? 7 : 6;

    logic       cmf_q;
    logic       ovf_q;
    logic       mode_q;
    logic       ie_q;
    logic [1:0] req_q;
    logic [2:0] cks_q;
    logic       unused_wdata;

    assign unused_wdata = ^wdata_i;

    // Flags: hardware set, software clear by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmf_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            cmf_q <= match_hit_i || (cmf_q && !(wr_ctrl_i && !wdata_i[CMF_BIT]));
            ovf_q <= WIDE && (wrap_hit_i || (ovf_q && !(wr_ctrl_i && !wdata_i[14])));
        end
    end

    // Writable configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            ie_q   <= 1'b0;
            req_q  <= 2'b00;
            cks_q  <= 3'd0;
        end else if (wr_ctrl_i) begin
            ie_q   <= wdata_i[IE_BIT];
            mode_q <= WIDE ? wdata_i[8] : 1'b0;
            req_q  <= WIDE ? wdata_i[5:4] : 2'b00;
            cks_q  <= WIDE ? wdata_i[2:0] : {1'b0, wdata_i[1:0]};
        end
    end

    // Read-back image per flavour
    generate
        if (WIDE) begin : g_wide
            always_comb begin
                ctrl_rd_o     = '0;
                ctrl_rd_o[15] = cmf_q;
                ctrl_rd_o[14] = ovf_q;
                ctrl_rd_o[13] = pend_i;
                ctrl_rd_o[8]  = mode_q;
                ctrl_rd_o[7]  = ie_q;
                ctrl_rd_o[5:4] = req_q;
                ctrl_rd_o[2:0] = cks_q;
            end
        end else begin : g_narrow
            always_comb begin
                ctrl_rd_o      = '0;
                ctrl_rd_o[7]   = cmf_q;
                ctrl_rd_o[6]   = ie_q;
                ctrl_rd_o[1:0] = cks_q[1:0];
            end
        end
    endgenerate

    // Tick source, single-shot hold and interrupt request
    always_comb begin
        src_o  = decode_cks(WIDE, cks_q);
        hold_o = WIDE && !mode_q && cmf_q;
        irq_o  = cmf_q && (ie_q || (WIDE && req_q == 2'b10));
    end

    // R4: a match always leaves the match flag set
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit_i |=> cmf_q);

    // R5: an unmatched wrap sets the overflow flag
    a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (WIDE && wrap_hit_i) |=> ovf_q);

    // R10: the request stays up until a control write
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_ctrl_i) |=> irq_o);

endmodule

// File: rtl/cmt_channel.sv
// Top of one compare match timer channel: register decode, read mux,
// prescaler, counter and control. Assumes combinational reads and a
// single write per cycle.
module cmt_channel
    import cmt_pkg::*;
#(
    parameter bit  WIDE       = 1'b1,
    parameter int  SYNC_TICKS = 2,
    localparam int CNT_W      = WIDE ? 32 : 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ref_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    logic              wr_ctrl;
    logic              wr_cnt;
    logic              wr_cmp;
    logic              cnt_en;
    logic              hold;
    logic              pend;
    logic              match_hit;
    logic              wrap_hit;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [CTRL_W-1:0] ctrl_rd;
    tick_src_t         src;

    // Write strobe decode
    always_comb begin
        wr_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
        wr_cnt  = wr_en && (reg_sel_e'(wr_sel) == SEL_CNT);
        wr_cmp  = wr_en && (reg_sel_e'(wr_sel) == SEL_CMP);
    end

    cmt_prescale u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .ref_tick_i (ref_tick),
        .src_i      (src),
        .cnt_en_o   (cnt_en)
    );

    cmt_counter #(
        .CNT_W      (CNT_W),
        .SYNC_TICKS (SYNC_TICKS)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .cnt_en_i    (cnt_en),
        .hold_i      (hold),
        .ref_tick_i  (ref_tick),
        .wr_cnt_i    (wr_cnt),
        .wr_cmp_i    (wr_cmp),
        .wdata_i     (wr_data),
        .cnt_o       (cnt),
        .cmp_o       (cmp),
        .pend_o      (pend),
        .match_hit_o (match_hit),
        .wrap_hit_o  (wrap_hit)
    );

    cmt_ctrl #(
        .WIDE (WIDE)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr_ctrl),
        .wdata_i     (wr_data[CTRL_W-1:0]),
        .match_hit_i (match_hit),
        .wrap_hit_i  (wrap_hit),
        .pend_i      (pend),
        .ctrl_rd_o   (ctrl_rd),
        .src_o       (src),
        .hold_o      (hold),
        .irq_o       (irq)
    );

    // Read multiplexer
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_CTRL: rd_data = CNT_W'(ctrl_rd);
            SEL_CNT:  rd_data = cnt;
            SEL_CMP:  rd_data = cmp;
            default:  rd_data = '0;
        endcase
    end

    // R1: first cycle out of reset shows the reset image
    a_r1_reset_image: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0 && cmp == '1 && ctrl_rd == '0 && !irq));

endmodule

// File: tb/sim_cmt_channel.sv
// Scoreboard bench: driver tasks queue expected values, a monitor on the
// falling edge pops and compares them. u0 is the wide flavour, u1 narrow.
module sim_cmt_channel;

    typedef struct {
        int          dut;
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        run0 = 1'b0, run1 = 1'b0;
    logic        wr_en0 = 1'b0, wr_en1 = 1'b0;
    logic [1:0]  wr_sel0 = '0, wr_sel1 = '0, rd_sel0 = '0, rd_sel1 = '0;
    logic [31:0] wr_data0 = '0, rd_data0;
    logic [15:0] wr_data1 = '0, rd_data1;
    logic        irq0, irq1;
    item_t       q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cmt_channel #(.WIDE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run0), .ref_tick(ref_tick),
        .wr_en(wr_en0), .wr_sel(wr_sel0), .wr_data(wr_data0),
        .rd_sel(rd_sel0), .rd_data(rd_data0), .irq(irq0));

    cmt_channel #(.WIDE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .run(run1), .ref_tick(ref_tick),
        .wr_en(wr_en1), .wr_sel(wr_sel1), .wr_data(wr_data1),
        .rd_sel(rd_sel1), .rd_data(rd_data1), .irq(irq1));

    // Monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            if (it.dut == 0) act = it.is_irq ? {31'd0, irq0} : rd_data0;
            else             act = it.is_irq ? {31'd0, irq1} : {16'd0, rd_data1};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(int d, bit is_irq, logic [1:0] sel, logic [31:0] exp, string tag);
        item_t it;
        if (d == 0) rd_sel0 = sel; else rd_sel1 = sel;
        it.dut = d; it.is_irq = is_irq; it.exp = exp; it.tag = tag;
        q.push_back(it);
        step(1);
    endtask

    task automatic wr(int d, logic [1:0] sel, logic [31:0] data, bit with_tick);
        if (d == 0) begin wr_en0 = 1'b1; wr_sel0 = sel; wr_data0 = data; end
        else        begin wr_en1 = 1'b1; wr_sel1 = sel; wr_data1 = data[15:0]; end
        ref_tick = with_tick;
        step(1);
        wr_en0 = 1'b0; wr_en1 = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) begin
            ref_tick = 1'b1; step(1);
            ref_tick = 1'b0; step(1);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset image
        chk(0, 0, 2'd0, 32'h0, "R1 ctrl");
        chk(0, 0, 2'd1, 32'h0, "R1 cnt");
        chk(0, 0, 2'd2, 32'hFFFF_FFFF, "R1 cmp");
        chk(0, 1, 2'd0, 32'h0, "R1 irq");
        chk(1, 0, 2'd2, 32'h0000_FFFF, "R1 narrow cmp");
        chk(1, 0, 2'd0, 32'h0, "R1 narrow ctrl");
        // R6 writable mask, unused select
        wr(0, 2'd0, 32'hFFFF, 0);
        chk(0, 0, 2'd0, 32'h01B7, "R6 mask");
        chk(0, 0, 2'd3, 32'h0, "R6 sel3");
        wr(0, 2'd0, 32'h0107, 0);
        // R2 stopped, then R3 code 7 counts every reference tick
        tick(3);
        chk(0, 0, 2'd1, 32'd0, "R2 stopped");
        run0 = 1'b1;
        tick(3);
        chk(0, 0, 2'd1, 32'd3, "R3 ref div1");
        // R7 deferred counter write
        wr(0, 2'd1, 32'd100, 0);
        chk(0, 0, 2'd1, 32'd3, "R7 old value");
        chk(0, 0, 2'd0, 32'h2107, "R7 write flag");
        tick(1);
        chk(0, 0, 2'd1, 32'd4, "R7 after one tick");
        tick(1);
        chk(0, 0, 2'd1, 32'd100, "R7 landed");
        chk(0, 0, 2'd0, 32'h0107, "R7 flag low");
        // R4 match and wrap
        wr(0, 2'd2, 32'd102, 0);
        tick(2);
        chk(0, 0, 2'd1, 32'd102, "R4 at compare");
        chk(0, 0, 2'd0, 32'h0107, "R4 no flag yet");
        tick(1);
        chk(0, 0, 2'd1, 32'd0, "R4 wrapped");
        chk(0, 0, 2'd0, 32'h8107, "R4 flag");
        // R8 compare rewritten while running, period 4
        wr(0, 2'd2, 32'd3, 0);
        tick(3);
        chk(0, 0, 2'd1, 32'd3, "R8 at new compare");
        tick(1);
        chk(0, 0, 2'd1, 32'd0, "R8 wrap");
        // R10 request types
        chk(0, 1, 2'd0, 32'h0, "R10 no enable");
        wr(0, 2'd0, 32'h8117, 0);
        chk(0, 1, 2'd0, 32'h0, "R10 type 01");
        chk(0, 0, 2'd0, 32'h8117, "R6 write one keeps flag");
        wr(0, 2'd0, 32'h8127, 0);
        chk(0, 1, 2'd0, 32'h1, "R10 type 10");
        wr(0, 2'd0, 32'h0127, 0);
        chk(0, 0, 2'd0, 32'h0127, "R6 clear flag");
        chk(0, 1, 2'd0, 32'h0, "R10 cleared");
        wr(0, 2'd0, 32'h0187, 0);
        tick(4);
        tick(2);
        chk(0, 1, 2'd0, 32'h1, "R10 enable held");
        chk(0, 0, 2'd1, 32'd2, "R4 continues");
        // Same-cycle clear and match: set wins
        wr(0, 2'd0, 32'h0187, 0);
        tick(1);
        wr(0, 2'd0, 32'h0187, 1);
        chk(0, 0, 2'd0, 32'h8187, "R6 set beats clear");
        chk(0, 0, 2'd1, 32'd0, "R4 wrap on collision");
        wr(0, 2'd0, 32'h0187, 0);
        // R9 single-shot hold
        wr(0, 2'd0, 32'h0087, 0);
        tick(4);
        tick(3);
        chk(0, 0, 2'd1, 32'd0, "R9 held");
        chk(0, 0, 2'd0, 32'h8087, "R9 flag");
        wr(0, 2'd0, 32'h0087, 0);
        tick(2);
        chk(0, 0, 2'd1, 32'd2, "R9 resumed");
        // R5 overflow
        wr(0, 2'd0, 32'h0107, 0);
        wr(0, 2'd1, 32'hFFFF_FFFE, 0);
        tick(2);
        chk(0, 0, 2'd1, 32'hFFFF_FFFE, "R7 load near max");
        tick(2);
        chk(0, 0, 2'd1, 32'd0, "R5 wrapped");
        chk(0, 0, 2'd0, 32'h4107, "R5 overflow flag");
        // R3 system clock and reference divisors
        run0 = 1'b0;
        wr(0, 2'd2, 32'd1000, 0);
        wr(0, 2'd0, 32'h0100, 0);
        run0 = 1'b1; step(80); run0 = 1'b0;
        chk(0, 0, 2'd1, 32'd10, "R3 clk div8");
        wr(0, 2'd0, 32'h0101, 0);
        run0 = 1'b1; step(64); run0 = 1'b0;
        chk(0, 0, 2'd1, 32'd12, "R3 clk div32");
        wr(0, 2'd0, 32'h0104, 0);
        run0 = 1'b1; tick(16); run0 = 1'b0;
        chk(0, 0, 2'd1, 32'd14, "R3 ref div8");
        tick(3);
        chk(0, 0, 2'd1, 32'd14, "R2 ticks while stopped");
        // R11 narrow flavour
        wr(1, 2'd2, 32'd2, 0);
        wr(1, 2'd0, 32'h0040, 0);
        run1 = 1'b1; step(24); run1 = 1'b0;
        chk(1, 0, 2'd1, 32'd0, "R11 wrap");
        chk(1, 0, 2'd0, 32'h00C0, "R11 flag");
        chk(1, 1, 2'd0, 32'h1, "R11 irq");
        wr(1, 2'd0, 32'h0040, 0);
        chk(1, 1, 2'd0, 32'h0, "R11 irq cleared");
        wr(1, 2'd0, 32'hFFFF, 0);
        chk(1, 0, 2'd0, 32'h0043, "R11 narrow mask");
        step(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule